// File: doc/BRIEF.md
# Repeated-Addition Squaring Unit

This block squares an unsigned operand without a multiplier array. After a start request it clears a wide accumulator. It then adds the operand into the accumulator once per clock. A step counter stops the additions when their number equals the operand's value. The result therefore equals the operand times itself, and the total latency grows linearly with the operand.

The start request does not clear the accumulator directly. It first passes through a flip-flop, which drives an active-low clear into the accumulator and the step counter. A trigger stage opens the adder only while an operation is armed and the step count is below the operand. The operand input must be held stable from the start request until done is seen. Done stays high, and the result stays frozen, until the next start.

Top module: `rep_square`

## Requirements
- R1: After reset, and before any start, result reads 0 and done reads 0.
- R2: For every operand m in 0..255, the result when done is high equals m*m, exact in the 16-bit result.
- R3: Counting from the clock edge that last samples start high, done first reads high after exactly m+1 further edges.
- R4: An operand of 0 gives a result of 0, with done high after one edge.
- R5: A start sampled on an edge forces the result to 0 on the following edge, whatever value it held before.
- R6: Done reads 0 from the edge that samples start until the completing edge of R3.
- R7: While done is high and start is low, the result does not change from one cycle to the next.
- R8: While an operation runs, the result after the k-th addition edge (k = 1..m) equals k*m.
- R9: While start is held high over several edges, the accumulator stays cleared. Timing for R3 is counted from the last edge with start high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to clear and begin a new squaring |
| operand | input | 8 | Unsigned value to square; held stable during an operation |
| result | output | 16 | Accumulator contents; the square once done is high |
| done | output | 1 | High once the required number of additions has completed |

## Verification
The sweep runs every operand from 0 to 255 back to back. Each run starts from the previous square, so the clear on the edge after start must be seen to wipe a nonzero value. On every cycle the sweep compares the running sum with k*m and compares done with the expected completion cycle. This separates an off-by-one addition count from a wrong clear delay or a stuck trigger. Operand 0 exercises the case where no addition happens. Operands 255 and 128 drive the upper result bits and the carry chain. A start held over three edges, followed by a hold of several idle cycles after done, shows that the clear repeats and that the result stays frozen.

// File: rtl/sq_pkg.sv
package sq_pkg;
   // Adder implementation choice for the accumulator
   typedef enum logic {
      ADD_BEHAV  = 1'b0,
      ADD_RIPPLE = 1'b1
   } adder_kind_e;

   function automatic int acc_width(input int op_w);
      return 2 * op_w;
   endfunction
endpackage

// File: rtl/sq_clear_stage.sv
module sq_clear_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_req,
   output logic clr_n
);
   logic clr_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_n_q <= 1'b1;
      else        clr_n_q <= ~clear_req;
   end

   assign clr_n = clr_n_q;

   // R5
   clear_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |=> !clr_n);
endmodule

// File: rtl/sq_add_gate.sv
module sq_add_gate #(
   parameter int OP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_n,
   input  logic [OP_W-1:0] limit,
   output logic            add_en,
   output logic            finished
);
   logic [OP_W-1:0] cnt_q;
   logic            armed_q;
   logic            below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (!clr_n) begin
         armed_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!clr_n) begin
         cnt_q <= '0;
      end else if (add_en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign below    = (cnt_q != limit);
   assign add_en   = armed_q & clr_n & below;
   assign finished = armed_q & clr_n & ~below;

   // R8
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |=> cnt_q == $past(cnt_q) + 1'b1);

   // R6
   no_finish_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> !finished && !add_en);
endmodule

// File: rtl/sq_accum.sv
module sq_accum
   import sq_pkg::*;
#(
   parameter int          OP_W  = 8,
   parameter int          ACC_W = 16,
   parameter adder_kind_e KIND  = ADD_RIPPLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             en,
   input  logic [OP_W-1:0]  addend,
   output logic [ACC_W-1:0] acc
);
   localparam int PAD_W = ACC_W - OP_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] ext;
   logic [ACC_W-1:0] sum;

   assign ext = {{PAD_W{1'b0}}, addend};

   generate
      if (KIND == ADD_BEHAV) begin : g_behav
         assign sum = acc_q + ext;
      end else begin : g_ripple
         logic [ACC_W-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < ACC_W; i++) begin : g_bit
            assign sum[i] = acc_q[i] ^ ext[i] ^ carry[i];
            if (i < ACC_W - 1) begin : g_c
               assign carry[i+1] = (acc_q[i] & ext[i]) |
                                   (carry[i] & (acc_q[i] ^ ext[i]));
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (!clr_n) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= sum;
      end
   end

   assign acc = acc_q;

   // R5
   acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> acc_q == '0);

   // R8
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && clr_n |=> acc_q == $past(acc_q) + $past(ext));
endmodule

// File: rtl/rep_square.sv
module rep_square
   import sq_pkg::*;
#(
   parameter int          OP_W = 8,
   parameter adder_kind_e KIND = ADD_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   operand,
   output logic [2*OP_W-1:0] result,
   output logic              done
);
   localparam int ACC_W = acc_width(OP_W);

   generate
      if (OP_W < 2 || OP_W > 32) begin : g_bad_width
         $error("rep_square: OP_W out of supported range");
      end
   endgenerate

   logic clr_n;
   logic add_en;
   logic finished;

   sq_clear_stage u_clear (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_req (start),
      .clr_n     (clr_n)
   );

   sq_add_gate #(.OP_W(OP_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .limit    (operand),
      .add_en   (add_en),
      .finished (finished)
   );

   sq_accum #(.OP_W(OP_W), .ACC_W(ACC_W), .KIND(KIND)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_n  (clr_n),
      .en     (add_en),
      .addend (operand),
      .acc    (result)
   );

   assign done = finished;

   // R7
   hold_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(result));

   // R6
   done_drops_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
endmodule

// File: tb/rep_square_bench.sv
module rep_square_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  operand = '0;
   logic [15:0] result;
   logic        done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   rep_square u_rep_square (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .operand (operand),
      .result  (result),
      .done    (done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // run one operation; start held for hold_n edges; timing counted from the last
   task automatic run_op(input int m, input int hold_n);
      operand = 8'(m);
      start = 1'b1;
      for (int h = 0; h < hold_n; h++) begin
         @(posedge clk);
         @(negedge clk);
         if (h > 0) chk("R9 clear while start held", int'(result), 0);
      end
      start = 1'b0;
      chk("R6 done low after start", int'(done), 0);
      for (int c = 1; c <= m + 1; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (c == 1) chk("R5 cleared after start", int'(result), 0);
         else        chk("R8 running sum", int'(result), (c - 1) * m);
         if (c <= m) chk("R6 done low while running", int'(done), 0);
         else        chk("R3 done at m+1", int'(done), 1);
      end
      if (m == 0) chk("R4 zero operand", int'(result), 0);
      chk("R2 square", int'(result), m * m);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset result", int'(result), 0);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle result", int'(result), 0);
      chk("R1 idle done", int'(done), 0);

      for (int m = 0; m < 256; m++) run_op(m, 1);

      // R7: result and done hold while idle after completion
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R7 result held", int'(result), 255 * 255);
         chk("R7 done held", int'(done), 1);
      end

      // R9: long start pulse, then a few more operands
      run_op(5, 3);
      run_op(0, 2);
      run_op(128, 1);
      run_op(255, 4);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule